// File: doc/BRIEF.md
# Phase-Overlap PWM Generator

This block produces a fixed-frequency pulse-width-modulated output from two phase accumulators that advance by the same step every clock. Because the step is shared, each accumulator's top bit is a symmetric square wave, and both waves have the same frequency. Oscillator B runs ahead of oscillator A by a programmable phase offset. The two top bits are ORed together. The result is high for half a period plus the offset, so it covers 50% to 100%. An inversion control XORs the combined wave, which reflects the duty into the 0% to 50% range.

To request a duty `d` (a fraction of `2^ACC_W`), use `d >= HALF` with inversion off and an offset of `d - HALF`. Below half, use inversion on with an offset of `HALF - d`. The step sets the frequency alone, and the frequency does not change when the duty does. A new offset and inversion setting take effect together, only when A's top bit rises. No partial or mixed period is ever emitted.

Top module: `pwm_dual_osc`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is 0 whatever the other inputs are.
- R2: `pwm_out` is 0 in every cycle after a clock edge at which `enable` was sampled low. The first edge with `enable` high leaves A at 0 and B at `phase`. Each later edge advances both by `step`.
- R3: While enabled, A's accumulator advances by exactly `step` (mod `2^ACC_W`) per clock, so the period is `2^ACC_W / step` cycles.
- R4: With `invert` = 0 and offset `k` (0 to `2^(ACC_W-1)`), `pwm_out` is high for `2^(ACC_W-1) + k` accumulator counts per period. With `step` = s, that is `(2^(ACC_W-1)+k)/s` cycles.
- R5: With `invert` = 1 and offset `k`, `pwm_out` is high for `(2^(ACC_W-1) - k)/s` cycles per period.
- R6: Offset `2^(ACC_W-1)` gives a constant high output (100%) when not inverted and a constant low output (0%) when inverted.
- R7: `phase` and `invert` are captured together only on the clock where A's top bit goes from 0 to 1. A change at any other time does not alter the period in progress.
- R8: The period length stays `2^ACC_W / step` whatever the duty setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the oscillators. Low holds them at their start phase and forces the output low |
| step | input | ACC_W | Shared accumulator increment, which sets the frequency |
| phase | input | ACC_W | Phase lead of B over A, in accumulator counts |
| invert | input | 1 | Invert the ORed wave, for duties below half |
| pwm_out | output | 1 | PWM output |

## Verification
If the phase gap between the accumulators drifts or is loaded at the wrong moment, the high count of the next full period at the port moves away from `half ± offset`. The bench counts every cycle of each period, so such a fault shows within one period of the change. A setting applied early changes the count of the period that was running when the input moved. A wrong accumulator step changes the period length, and the period-aligned windows then see the wrong total within the first window.

// File: rtl/pwm_dual_osc.sv
module pwm_dual_osc #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [ACC_W-1:0] step,
  input  logic [ACC_W-1:0] phase,
  input  logic             invert,
  output logic             pwm_out
);
  localparam int MSB = ACC_W - 1;
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << MSB;

  logic [ACC_W-1:0] acc_a, acc_b, off_q, a_next;
  logic             inv_q, run, a_rise;

  assign a_next = acc_a + step;
  assign a_rise = ~acc_a[MSB] & a_next[MSB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      acc_a <= '0;
      acc_b <= '0;
      off_q <= '0;
      inv_q <= 1'b0;
    end else if (!enable) begin
      run   <= 1'b0;
      acc_a <= '0;
      acc_b <= phase;
      off_q <= phase;
      inv_q <= invert;
    end else if (!run) begin
      run <= 1'b1;
    end else if (a_rise) begin
      acc_a <= a_next;
      acc_b <= a_next + phase;
      off_q <= phase;
      inv_q <= invert;
    end else begin
      acc_a <= a_next;
      acc_b <= acc_b + step;
    end
  end

  assign pwm_out = run & ((acc_a[MSB] | acc_b[MSB]) ^ inv_q);

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !pwm_out);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> acc_a == ACC_W'($past(acc_a) + $past(step)));

  assert_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ACC_W'(acc_b - acc_a) == off_q);

  assert_full_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !inv_q && off_q == HALF) |-> pwm_out);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(a_rise)) |-> ($stable(inv_q) && $stable(off_q)));
endmodule

// File: tb/pwm_dual_osc_bench.sv
module pwm_dual_osc_bench;
  localparam int W = 8;

  logic         clk = 1'b0, rst_n = 1'b0, enable = 1'b0, invert = 1'b0;
  logic [W-1:0] step = 8'd1, phase = '0;
  logic         pwm_out;

  always #5 clk = ~clk;

  pwm_dual_osc #(.ACC_W(W)) u_pwm_dual_osc (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step(step),
    .phase(phase), .invert(invert), .pwm_out(pwm_out)
  );

  typedef struct { int len; int exp; string req; } item_t;
  item_t sb[$];
  int errors = 0, checks = 0;
  int half_len = 128, nwin = 0, cur_step = 1;
  logic go = 1'b0, mon_busy = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: counts high cycles over each period that starts at A's rising point
  initial begin
    forever begin
      wait (go);
      go = 1'b0;
      mon_busy = 1'b1;
      repeat (half_len) @(posedge clk);
      for (int w = 0; w < nwin; w++) begin
        int cnt;
        item_t it;
        cnt = 0;
        for (int i = 0; i < 2 * half_len; i++) begin
          @(negedge clk);
          if (pwm_out) cnt++;
        end
        if (sb.size() == 0) check(1'b0, "scoreboard-empty", cnt, -1);
        else begin
          it = sb.pop_front();
          check(cnt == it.exp, it.req, cnt, it.exp);
        end
      end
      mon_busy = 1'b0;
    end
  end

  task automatic start_run(input int st, input int n);
    @(negedge clk);
    enable = 1'b0;
    invert = 1'b1;
    step = W'(st);
    cur_step = st;
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R2 idle low", pwm_out, 0);
    enable = 1'b1;
    @(posedge clk);
    half_len = 128 / st;
    nwin = n;
    go = 1'b1;
    repeat (half_len / 2) @(negedge clk);
  endtask

  // Driver: setting changes mid-period; must only apply at the next A rise (R7)
  task automatic do_case(input int off, input bit inv, input string req);
    phase = W'(off);
    invert = inv;
    sb.push_back('{256 / cur_step, (inv ? 128 - off : 128 + off) / cur_step, req});
    repeat (2 * half_len) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    invert = 1'b1;
    enable = 1'b1;
    repeat (2) @(negedge clk);
    check(pwm_out == 1'b0, "R1 reset low", pwm_out, 0);
    enable = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 1'b0, "R1 after reset low", pwm_out, 0);

    start_run(1, 8);
    do_case(0,   1'b0, "R4 offset 0 non-inverted, R3 R8 period");
    do_case(40,  1'b0, "R4 offset 40 non-inverted R7");
    do_case(128, 1'b0, "R6 full high");
    do_case(0,   1'b1, "R5 offset 0 inverted");
    do_case(40,  1'b1, "R5 offset 40 inverted R7");
    do_case(128, 1'b1, "R6 full low");
    do_case(100, 1'b0, "R4 offset 100 R8");
    do_case(128, 1'b0, "R6 full high again");
    @(negedge clk);
    wait (!mon_busy);
    @(negedge clk);
    check(pwm_out == 1'b1, "R6 high before disable", pwm_out, 1);
    enable = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R2 disable forces low", pwm_out, 0);

    start_run(2, 3);
    do_case(64,  1'b0, "R3 step 2 offset 64");
    do_case(30,  1'b1, "R5 step 2 offset 30 R7");
    do_case(128, 1'b0, "R8 step 2 full high");
    @(negedge clk);
    wait (!mon_busy);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule